// File: doc/BRIEF.md
# Video Sync Pin Master/Slave Controller

This block sits on the pixel input port of a video encoder and owns its three sync pins: horizontal, vertical and frame. Each pin has a direction bit and a polarity bit. A pin set as an output is driven with an internally produced sync pulse at the selected level. A pin set as an input is passed through a two-flop synchronizer and watched for its trigger edge. From those edges the block produces one-cycle horizontal and vertical trigger pulses for a downstream raster timing generator. The horizontal and vertical triggers can each come from their own pin or from the shared frame pin.

A line counter runs from 0 to the programmed line length minus one. It is exposed as `h_count`. In slave operation a horizontal trigger edge restarts the counter. In master operation the counter wraps by itself and shapes the horizontal output pulse. An optional advance mode moves the horizontal trigger 128 pixel clocks earlier, which suits a horizontal sync that arrives late. In that mode the trigger fires at count `len-128` of the line that the previous edge started.

All configuration inputs are captured into a shadow set only at a line boundary. This keeps the sync outputs free of glitches. The controller FSM has two states. In LOAD, which it enters at reset, it captures the configuration and zeroes the counter. The transition LOAD→RUN is taken on the first clock after reset. The transition RUN→RUN repeats on every later clock, and the shadow set is reloaded on each RUN cycle whose next count is 0.

Top module: `sync_port_ctrl`

## Requirements
- R1: While reset is asserted, all of `sync_oe`, `h_trig`, `v_trig` and `h_count` are 0.
- R2: `sync_oe[i]` equals the active direction bit for pin i, where bit 0 is horizontal, bit 1 is vertical and bit 2 is frame. A value of 1 means the pin is driven and 0 means it is an input.
- R3: `sync_out[0]` is active for the counts 0 to width-1 of each line. `sync_out[1]` follows `gen_vsync` and `sync_out[2]` follows `gen_fsync`. Each output is inverted when its polarity bit is 1, so polarity 0 gives active HIGH and polarity 1 gives active LOW.
- R4: A pin used as a slave source triggers on its rising edge when its polarity bit is 0 and on its falling edge when the bit is 1. Assume a new level is first sampled at clock edge k. The trigger is then high in the cycle between edges k+1 and k+2.
- R5: The horizontal source is the frame pin only when `cfg_h_frame` and `cfg_ext_frame_en` are both 1. Otherwise it is the horizontal pin.
- R6: The vertical source is the frame pin only when `cfg_v_frame` and `cfg_ext_frame_en` are both 1. Otherwise it is the vertical pin. `v_trig` fires on that pin's trigger edge only if the pin is an input.
- R7: Every trigger pulse lasts exactly one clock.
- R8: `h_count` counts 0 to len-1 and then wraps. When the horizontal source pin is an input, a trigger edge on it makes the next count 0.
- R9: When the selected horizontal source pin is an output, `h_trig` is high exactly in the cycles where `h_count` is 0.
- R10: With the advance bit set, a horizontal input source and len greater than 128, `h_trig` fires when `h_count` equals len-128, and source edges produce no `h_trig`. With len of 128 or less, the advance bit has no effect.
- R11: Configuration input changes take effect only on the first cycle after reset or on the cycle where `h_count` becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 3 | Per-pin direction (bit0 H, bit1 V, bit2 F), 1 = output |
| cfg_pol | input | 3 | Per-pin polarity, 1 = active LOW / falling edge |
| cfg_h_frame | input | 1 | Take horizontal trigger from frame pin |
| cfg_v_frame | input | 1 | Take vertical trigger from frame pin |
| cfg_ext_frame_en | input | 1 | Enable for frame-pin sourcing |
| cfg_h_advance | input | 1 | Fire horizontal trigger 128 clocks early |
| cfg_line_len | input | CNT_W | Pixel clocks per line |
| cfg_hs_width | input | CNT_W | Master horizontal pulse width |
| sync_in | input | 3 | Pad input values of the three pins |
| gen_vsync | input | 1 | Internal vertical pulse, active high |
| gen_fsync | input | 1 | Internal frame pulse, active high |
| sync_out | output | 3 | Pad output values |
| sync_oe | output | 3 | Pad output enables |
| h_trig | output | 1 | Horizontal trigger pulse |
| v_trig | output | 1 | Vertical trigger pulse |
| h_count | output | CNT_W | Line position counter |

## Verification
The bench targets several corner cases. The first is a frame-pin source with the external enable low. A design that ignored the enable would restart lines on frame edges instead of on horizontal edges. A second case flips polarity and length in the middle of a line. A design that applied them at once would show a shortened or inverted pulse before the counter wraps. The advance mode is exercised at lengths of 200, 129 and 100. An off-by-one in the `len > 128` test, or a leftover edge trigger in advance mode, would show up as a misplaced or doubled `h_trig`. A further case sources a trigger from a pin set as an output. That pin must give a counter-based horizontal trigger and no vertical trigger.

// File: rtl/spc_pkg.sv
package spc_pkg;

    localparam int NPINS = 3;
    localparam int PIN_H = 0;
    localparam int PIN_V = 1;
    localparam int PIN_F = 2;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_RUN  = 1'b1
    } spc_state_e;

    typedef struct packed {
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] pol;
        logic             h_frame;
        logic             v_frame;
        logic             ext_en;
        logic             h_adv;
    } spc_mode_t;

endpackage

// File: rtl/spc_edge_det.sv
module spc_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pin;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    // R7: an edge pulse never lasts two cycles
    a_r7_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    a_r7_fall_single: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/spc_line_ctrl.sv
module spc_line_ctrl
    import spc_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  spc_mode_t        mode_in,
    input  logic [CNT_W-1:0] len_in,
    input  logic [CNT_W-1:0] wid_in,
    input  logic             restart,
    output spc_mode_t        mode_q,
    output logic [CNT_W-1:0] len_q,
    output logic [CNT_W-1:0] wid_q,
    output logic [CNT_W-1:0] count,
    output logic             running
);
    spc_state_e       state_q, state_d;
    logic [CNT_W:0]   cnt_inc;
    logic [CNT_W-1:0] cnt_nxt;
    logic             load;

    always_comb begin
        cnt_inc = {1'b0, count} + {{CNT_W{1'b0}}, 1'b1};
        if (restart || (cnt_inc >= {1'b0, len_q}))
            cnt_nxt = '0;
        else
            cnt_nxt = cnt_inc[CNT_W-1:0];
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOAD;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        running = 1'b0;
        load    = 1'b0;
        unique case (state_q)
            ST_LOAD: begin
                load    = 1'b1;
                state_d = ST_RUN;
            end
            ST_RUN: begin
                running = 1'b1;
                load    = (cnt_nxt == '0);
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count  <= '0;
            mode_q <= '0;
            len_q  <= '0;
            wid_q  <= '0;
        end else begin
            count <= (state_q == ST_LOAD) ? '0 : cnt_nxt;
            if (load) begin
                mode_q <= mode_in;
                len_q  <= len_in;
                wid_q  <= wid_in;
            end
        end
    end

    // R8: a slave restart always lands on count 0
    a_r8_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (running && restart) |=> (count == '0));
    // R8: the counter stays inside the active line length
    a_r8_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ((count < len_q) || (count == '0)));
    // R11: shadow configuration holds except at a line boundary
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (running && (cnt_nxt != '0)) |=> ($stable(mode_q) && $stable(len_q) && $stable(wid_q)));

endmodule

// File: rtl/sync_port_ctrl.sv
module sync_port_ctrl
    import spc_pkg::*;
#(
    parameter int CNT_W    = 12,
    parameter int ADV_CLKS = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       cfg_dir,
    input  logic [2:0]       cfg_pol,
    input  logic             cfg_h_frame,
    input  logic             cfg_v_frame,
    input  logic             cfg_ext_frame_en,
    input  logic             cfg_h_advance,
    input  logic [CNT_W-1:0] cfg_line_len,
    input  logic [CNT_W-1:0] cfg_hs_width,
    input  logic [2:0]       sync_in,
    input  logic             gen_vsync,
    input  logic             gen_fsync,
    output logic [2:0]       sync_out,
    output logic [2:0]       sync_oe,
    output logic             h_trig,
    output logic             v_trig,
    output logic [CNT_W-1:0] h_count
);
    localparam logic [CNT_W-1:0] ADV_V = CNT_W'(ADV_CLKS);

    spc_mode_t        mode_in, mode;
    logic [CNT_W-1:0] len_q, wid_q, count;
    logic             running;
    logic [NPINS-1:0] rise, fall, pin_trig;
    int unsigned      h_src, v_src;
    logic             h_slave, h_edge, adv_ok, restart;

    assign mode_in = '{dir: cfg_dir, pol: cfg_pol, h_frame: cfg_h_frame,
                       v_frame: cfg_v_frame, ext_en: cfg_ext_frame_en,
                       h_adv: cfg_h_advance};

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        spc_edge_det u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .pin  (sync_in[g]),
            .rise (rise[g]),
            .fall (fall[g])
        );
        assign pin_trig[g] = mode.pol[g] ? fall[g] : rise[g];
    end

    spc_line_ctrl #(.CNT_W(CNT_W)) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_in(mode_in),
        .len_in (cfg_line_len),
        .wid_in (cfg_hs_width),
        .restart(restart),
        .mode_q (mode),
        .len_q  (len_q),
        .wid_q  (wid_q),
        .count  (count),
        .running(running)
    );

    always_comb begin
        h_src   = (mode.h_frame && mode.ext_en) ? PIN_F : PIN_H;
        v_src   = (mode.v_frame && mode.ext_en) ? PIN_F : PIN_V;
        h_slave = !mode.dir[h_src];
        h_edge  = pin_trig[h_src];
        adv_ok  = mode.h_adv && (len_q > ADV_V);
        restart = h_slave && h_edge;

        if (!running)
            h_trig = 1'b0;
        else if (!h_slave)
            h_trig = (count == '0);
        else if (adv_ok)
            h_trig = (count == (len_q - ADV_V));
        else
            h_trig = h_edge;

        v_trig = running && !mode.dir[v_src] && pin_trig[v_src];

        sync_oe          = mode.dir;
        sync_out[PIN_H]  = (count < wid_q) ^ mode.pol[PIN_H];
        sync_out[PIN_V]  = gen_vsync ^ mode.pol[PIN_V];
        sync_out[PIN_F]  = gen_fsync ^ mode.pol[PIN_F];
    end

    assign h_count = count;

endmodule

// File: tb/test_sync_port_ctrl.sv
module test_sync_port_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int CNT_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       cfg_dir = '0, cfg_pol = '0;
    logic             cfg_h_frame = 0, cfg_v_frame = 0, cfg_ext_frame_en = 0, cfg_h_advance = 0;
    logic [CNT_W-1:0] cfg_line_len = 12'd20, cfg_hs_width = 12'd4;
    logic [2:0]       sync_in = '0;
    logic             gen_vsync = 0, gen_fsync = 0;
    logic [2:0]       sync_out, sync_oe;
    logic             h_trig, v_trig;
    logic [CNT_W-1:0] h_count;

    int checks = 0, fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sync_port_ctrl #(.CNT_W(CNT_W)) i_sync_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_dir(cfg_dir), .cfg_pol(cfg_pol),
        .cfg_h_frame(cfg_h_frame), .cfg_v_frame(cfg_v_frame),
        .cfg_ext_frame_en(cfg_ext_frame_en), .cfg_h_advance(cfg_h_advance),
        .cfg_line_len(cfg_line_len), .cfg_hs_width(cfg_hs_width),
        .sync_in(sync_in), .gen_vsync(gen_vsync), .gen_fsync(gen_fsync),
        .sync_out(sync_out), .sync_oe(sync_oe), .h_trig(h_trig),
        .v_trig(v_trig), .h_count(h_count));

    // behavioural reference model
    bit       m_started = 0;
    int       m_cnt = 0, m_len = 0, m_wid = 0;
    bit [2:0] m_dir = 0, m_pol = 0;
    bit       m_hfr = 0, m_vfr = 0, m_ext = 0, m_adv = 0;
    bit [2:0] p1 = 0, p2 = 0, p3 = 0;

    function automatic bit m_edge(int p);
        return m_pol[p] ? (p3[p] && !p2[p]) : (p2[p] && !p3[p]);
    endfunction

    function automatic int m_hsrc();
        return (m_hfr && m_ext) ? 2 : 0;
    endfunction

    task automatic m_load();
        m_dir = cfg_dir; m_pol = cfg_pol; m_hfr = cfg_h_frame; m_vfr = cfg_v_frame;
        m_ext = cfg_ext_frame_en; m_adv = cfg_h_advance;
        m_len = int'(cfg_line_len); m_wid = int'(cfg_hs_width);
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_started = 0; m_cnt = 0; m_dir = 0; m_pol = 0; m_hfr = 0; m_vfr = 0;
            m_ext = 0; m_adv = 0; m_len = 0; m_wid = 0; p1 = 0; p2 = 0; p3 = 0;
        end else begin
            if (!m_started) begin
                m_started = 1; m_cnt = 0; m_load();
            end else begin
                int nxt;
                bit rs;
                rs  = !m_dir[m_hsrc()] && m_edge(m_hsrc());
                nxt = rs ? 0 : ((m_cnt + 1 >= m_len) ? 0 : m_cnt + 1);
                if (nxt == 0) m_load();
                m_cnt = nxt;
            end
            p3 = p2; p2 = p1; p1 = sync_in;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        int  hs, vs;
        bit  hslave, advok, eh, ev;
        bit [2:0] eo;
        hs     = m_hsrc();
        vs     = (m_vfr && m_ext) ? 2 : 1;
        hslave = !m_dir[hs];
        advok  = m_adv && (m_len > 128);
        eh = m_started && (hslave ? (advok ? (m_cnt == m_len - 128) : m_edge(hs)) : (m_cnt == 0));
        ev = m_started && !m_dir[vs] && m_edge(vs);
        eo[0] = (m_cnt < m_wid) ^ m_pol[0];
        eo[1] = gen_vsync ^ m_pol[1];
        eo[2] = gen_fsync ^ m_pol[2];
        chk(sync_oe == m_dir, "R2", "sync_oe", sync_oe, m_dir);
        chk(sync_out == eo, "R3", "sync_out", sync_out, eo);
        chk(int'(h_count) == m_cnt, "R8 R11", "h_count", h_count, m_cnt);
        chk(h_trig == eh, "R4 R5 R7 R9 R10", "h_trig", h_trig, eh);
        chk(v_trig == ev, "R4 R6 R7", "v_trig", v_trig, ev);
    endtask

    task automatic run(int n, int hp, int vp, int fp);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            compare();
            sync_in[0] = (hp > 0) && ((i % hp) < 3);
            sync_in[1] = (vp > 0) && ((i % vp) < 4);
            sync_in[2] = (fp > 0) && ((i % fp) < 2);
            gen_vsync  = (i % 17) < 5;
            gen_fsync  = (i % 29) < 7;
        end
    endtask

    initial begin
        #1ms;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        cfg_dir = 3'b111; cfg_pol = 3'b000;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            // R1: reset state
            chk(sync_oe == 0 && !h_trig && !v_trig && h_count == 0, "R1", "reset outputs",
                {sync_oe, h_trig, v_trig, h_count != 0}, 0);
        end
        rst_n = 1'b1;
        // master, polarity high, then low with new length mid-line (R3 R9 R11)
        run(83, 0, 0, 0);
        cfg_pol = 3'b111; cfg_hs_width = 12'd7; cfg_line_len = 12'd25;
        run(90, 0, 0, 0);
        // slave from own pins, rising then mixed edges (R4 R6 R8)
        cfg_dir = 3'b000; cfg_pol = 3'b000; cfg_line_len = 12'd64; cfg_hs_width = 12'd5;
        run(220, 50, 120, 0);
        cfg_pol = 3'b011;
        run(220, 50, 90, 0);
        // frame source without enable falls back (R5 R6)
        cfg_pol = 3'b000; cfg_h_frame = 1; cfg_v_frame = 1; cfg_ext_frame_en = 0;
        run(160, 40, 70, 55);
        cfg_ext_frame_en = 1;
        run(220, 40, 70, 55);
        // frame pin driven while selected: counter trigger, no v trigger (R6 R9)
        cfg_dir = 3'b100;
        run(120, 40, 70, 55);
        // advance (R10)
        cfg_dir = 3'b000; cfg_h_frame = 0; cfg_v_frame = 0; cfg_ext_frame_en = 0;
        cfg_h_advance = 1; cfg_line_len = 12'd200;
        run(900, 200, 0, 0);
        cfg_line_len = 12'd129;
        run(600, 129, 0, 0);
        cfg_line_len = 12'd100;
        run(400, 100, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule